// File: doc/BRIEF.md
# Word-to-Byte Bus Sequencer

This block connects a core that works on 16-bit words to an external bus that carries one byte at a time. On that bus the low address lines also serve as the data lines. The core makes a single request: a byte address, a direction (read or write), a space (memory or I/O) and, for a write, a word of data. The block then runs two complete byte-wide bus cycles, one after the other. It writes the word out in two halves, or builds the word from the two bytes it reads back, and then tells the core that the transfer is finished.

Every bus cycle has four phases. In the first, the address goes out and a latch strobe is raised so that outside logic can capture the low address byte from the shared lines. In the second, exactly one active-low command strobe is asserted, and the block stays in this phase until the bus signals ready. In the third, the strobe is still held and the read byte is captured or the write byte is still driven. In the fourth, all strobes are released and the shared lines are not driven.

The core uses a simple request/busy/done handshake. The block ignores requests that arrive while a transfer is running. The upper address bits have their own output pins and hold their value for the whole cycle.

Top module: `byte_bus_bridge`

## Requirements
- R1: While reset is held and just after it is released, all four command strobes are high, the latch strobe is low, the shared-line output enable is low, and busy and done are both low.
- R2: One accepted request produces exactly two byte bus cycles. The first is at the request address A and the second at A+1.
- R3: The second address is A+1 modulo 2^20, so a request at 0xFFFFF uses 0xFFFFF and then 0x00000.
- R4: A write puts bits 7:0 of the word at A and bits 15:8 at A+1. The byte is on the shared lines with the output enable high for as long as the write strobe is low.
- R5: A read returns the byte from A in bits 7:0 and the byte from A+1 in bits 15:8. The read result output changes only on the cycle in which done is high after a read, so a write leaves it unchanged.
- R6: The command is memory-read for (write=0, io=0), memory-write for (1,0), I/O-read for (0,1) and I/O-write for (1,1). No more than one strobe is low at any time.
- R7: During the latch strobe, the shared lines carry address bits 7:0 with the output enable high and all command strobes high. The cycle after it always has a command strobe low. The upper address pins do not change while a strobe stays low.
- R8: While a read strobe is low, the output enable of the shared lines is low.
- R9: The command phase repeats for each clock in which ready is low. With ready held high, done appears 8 clocks after the accepting edge. Each extra low-ready clock per byte adds one clock.
- R10: Busy is high from the accepting edge until done. Done is high for exactly one clock, and busy is low in that clock. A request made while busy starts no bus cycle.
- R11: Between the two byte cycles, and after the second one, there is a clock with all strobes high and the output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request pulse from the core |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | 20 | Byte address of the low byte |
| req_wdata_i | input | 16 | Word to write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Assembled read word |
| ready_i | input | 1 | Bus ready, ends the command phase |
| ale_o | output | 1 | Address latch strobe |
| ad_o | output | 8 | Shared address/data lines, driven value |
| ad_oe_o | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Shared address/data lines, sampled value |
| a_hi_o | output | 12 | Address bits 19:8 |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 8-bit lanes and two lanes per word. With these values a single request at 0xFFFFF reaches the wrap to address zero, and the exact latency of 8 clocks plus two per wait clock can be predicted by hand. A bus model on the bench side decodes the strobes and keeps separate memory and I/O byte arrays. This lets the bench check the byte order, the space selection and the read assembly against addresses that were never written. It also inserts a chosen number of low-ready clocks per byte.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_REC
    } bus_phase_e;

endpackage

// File: rtl/bbr_seq.sv
module bbr_seq
    import bbr_pkg::*;
#(
    parameter int WORD_BYTES = 2,
    parameter int IDX_W      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             write_i,
    input  logic             io_i,
    input  logic             ready_i,
    output bus_phase_e       phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             write_o,
    output logic             io_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             finish_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    typedef struct packed {
        bus_phase_e       phase;
        logic [IDX_W-1:0] idx;
        logic             write;
        logic             io;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.phase = PH_ADDR;
                    st_d.idx   = '0;
                    st_d.write = write_i;
                    st_d.io    = io_i;
                end
            end
            PH_ADDR: st_d.phase = PH_CMD;
            PH_CMD: begin
                if (ready_i) begin
                    st_d.phase = PH_DATA;
                end
            end
            PH_DATA: st_d.phase = PH_REC;
            PH_REC: begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.phase = PH_ADDR;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, write: 1'b0, io: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign idx_o     = st_q.idx;
    assign write_o   = st_q.write;
    assign io_o      = st_q.io;
    assign accept_o  = (st_q.phase == PH_IDLE) && req_i;
    assign capture_o = (st_q.phase == PH_DATA);
    assign finish_o  = (st_q.phase == PH_REC) && (st_q.idx == LAST_IDX);
    assign busy_o    = (st_q.phase != PH_IDLE);
    assign done_o    = st_q.done;

endmodule

// File: rtl/bbr_addr.sv
module bbr_addr #(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] cur_o
);

    logic [ADDR_W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (accept_i) begin
            base_d = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    // Sum is truncated to ADDR_W bits, giving the wrap at the top of the space.
    assign cur_o = base_q + ADDR_W'(idx_i);

endmodule

// File: rtl/bbr_lanes.sv
module bbr_lanes #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 2,
    parameter int IDX_W      = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept_i,
    input  logic [WORD_BYTES*BYTE_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]             idx_i,
    input  logic                         capture_i,
    input  logic                         finish_i,
    input  logic                         read_i,
    input  logic [BYTE_W-1:0]            ad_i,
    output logic [BYTE_W-1:0]            wbyte_o,
    output logic [WORD_BYTES*BYTE_W-1:0] rdata_o
);

    localparam int WORD_W = WORD_BYTES * BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] stage;
        logic [WORD_W-1:0] rdata;
    } lane_state_t;

    lane_state_t ln_d, ln_q;
    logic [WORD_BYTES-1:0] lane_hit;

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lane_hit[g] = capture_i && (idx_i == IDX_W'(g));
    end

    always_comb begin
        ln_d = ln_q;
        if (accept_i) begin
            ln_d.wdata = wdata_i;
        end
        for (int k = 0; k < WORD_BYTES; k++) begin
            if (lane_hit[k]) begin
                ln_d.stage[k*BYTE_W +: BYTE_W] = ad_i;
            end
        end
        if (finish_i && read_i) begin
            ln_d.rdata = ln_q.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign wbyte_o = ln_q.wdata[idx_i*BYTE_W +: BYTE_W];
    assign rdata_o = ln_q.rdata;

endmodule

// File: rtl/bbr_pins.sv
module bbr_pins
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  bus_phase_e         phase_i,
    input  logic               write_i,
    input  logic               io_i,
    input  logic [ADDR_W-1:0]  cur_addr_i,
    input  logic [BYTE_W-1:0]  wbyte_i,
    output logic               ale_o,
    output logic [BYTE_W-1:0]  ad_o,
    output logic               ad_oe_o,
    output logic [ADDR_W-BYTE_W-1:0] a_hi_o,
    output logic               memr_n_o,
    output logic               memw_n_o,
    output logic               ior_n_o,
    output logic               iow_n_o
);

    logic strobe_on;

    always_comb begin
        strobe_on = (phase_i == PH_CMD) || (phase_i == PH_DATA);
        ale_o     = (phase_i == PH_ADDR);
        ad_o      = '0;
        ad_oe_o   = 1'b0;
        if (phase_i == PH_ADDR) begin
            ad_o    = cur_addr_i[BYTE_W-1:0];
            ad_oe_o = 1'b1;
        end else if (strobe_on && write_i) begin
            ad_o    = wbyte_i;
            ad_oe_o = 1'b1;
        end
        memr_n_o = !(strobe_on && !io_i && !write_i);
        memw_n_o = !(strobe_on && !io_i &&  write_i);
        ior_n_o  = !(strobe_on &&  io_i && !write_i);
        iow_n_o  = !(strobe_on &&  io_i &&  write_i);
    end

    assign a_hi_o = cur_addr_i[ADDR_W-1:BYTE_W];

endmodule

// File: rtl/byte_bus_bridge.sv
module byte_bus_bridge
    import bbr_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic                         req_write_i,
    input  logic                         req_io_i,
    input  logic [ADDR_W-1:0]            req_addr_i,
    input  logic [WORD_BYTES*BYTE_W-1:0] req_wdata_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [WORD_BYTES*BYTE_W-1:0] rdata_o,
    input  logic                         ready_i,
    output logic                         ale_o,
    output logic [BYTE_W-1:0]            ad_o,
    output logic                         ad_oe_o,
    input  logic [BYTE_W-1:0]            ad_i,
    output logic [ADDR_W-BYTE_W-1:0]     a_hi_o,
    output logic                         memr_n_o,
    output logic                         memw_n_o,
    output logic                         ior_n_o,
    output logic                         iow_n_o
);

    localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    bus_phase_e        phase;
    logic [IDX_W-1:0]  idx;
    logic              cur_write, cur_io;
    logic              accept, capture, finish;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] wbyte;

    bbr_seq #(.WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .write_i(req_write_i),
        .io_i(req_io_i), .ready_i(ready_i), .phase_o(phase), .idx_o(idx),
        .write_o(cur_write), .io_o(cur_io), .accept_o(accept),
        .capture_o(capture), .finish_o(finish), .busy_o(busy_o), .done_o(done_o)
    );

    bbr_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .addr_i(req_addr_i),
        .idx_i(idx), .cur_o(cur_addr)
    );

    bbr_lanes #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .wdata_i(req_wdata_i),
        .idx_i(idx), .capture_i(capture), .finish_i(finish),
        .read_i(!cur_write), .ad_i(ad_i), .wbyte_o(wbyte), .rdata_o(rdata_o)
    );

    bbr_pins #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_pins (
        .phase_i(phase), .write_i(cur_write), .io_i(cur_io),
        .cur_addr_i(cur_addr), .wbyte_i(wbyte), .ale_o(ale_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .a_hi_o(a_hi_o), .memr_n_o(memr_n_o),
        .memw_n_o(memw_n_o), .ior_n_o(ior_n_o), .iow_n_o(iow_n_o)
    );

endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
    parameter int HI_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale_o,
    input logic            ad_oe_o,
    input logic [HI_W-1:0] a_hi_o,
    input logic            memr_n_o,
    input logic            memw_n_o,
    input logic            ior_n_o,
    input logic            iow_n_o,
    input logic            busy_o,
    input logic            done_o
);

    logic any_low;
    assign any_low = !memr_n_o || !memw_n_o || !ior_n_o || !iow_n_o;

    p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!memr_n_o, !memw_n_o, !ior_n_o, !iow_n_o}) <= 1);

    p_ale_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (!any_low && ad_oe_o));

    p_ale_then_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> any_low);

    p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_low && $past(any_low)) |-> $stable(a_hi_o));

    p_read_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!memr_n_o || !ior_n_o) |-> !ad_oe_o);

    p_write_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!memw_n_o || !iow_n_o) |-> ad_oe_o);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_low) |-> (!ad_oe_o && !ale_o));

endmodule

bind byte_bus_bridge bbr_checker #(.HI_W(ADDR_W - BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ale_o(ale_o), .ad_oe_o(ad_oe_o),
    .a_hi_o(a_hi_o), .memr_n_o(memr_n_o), .memw_n_o(memw_n_o),
    .ior_n_o(ior_n_o), .iow_n_o(iow_n_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_byte_bus_bridge.sv
`timescale 1ns/1ps
module tb_byte_bus_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic        req_io_i = 1'b0;
    logic [19:0] req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        busy_o, done_o;
    logic [15:0] rdata_o;
    logic        ready_i = 1'b1;
    logic        ale_o;
    logic [7:0]  ad_o;
    logic        ad_oe_o;
    logic [7:0]  ad_i = 8'h5A;
    logic [11:0] a_hi_o;
    logic        memr_n_o, memw_n_o, ior_n_o, iow_n_o;

    byte_bus_bridge dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_write_i(req_write_i),
        .req_io_i(req_io_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .ready_i(ready_i),
        .ale_o(ale_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i),
        .a_hi_o(a_hi_o), .memr_n_o(memr_n_o), .memw_n_o(memw_n_o),
        .ior_n_o(ior_n_o), .iow_n_o(iow_n_o)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Bus model state and transaction log (kind: 0 memr, 1 memw, 2 ior, 3 iow).
    logic [7:0]  mem [256];
    logic [7:0]  iosp[256];
    logic [19:0] log_addr[64];
    int          log_kind[64];
    logic [7:0]  log_data[64];
    int          log_n = 0;
    logic [19:0] cur_a = '0;
    int          cur_kind = 0;
    logic [7:0]  cur_data = '0;
    logic        was_low = 1'b0;
    int          stall_cfg = 0;
    int          stall_left = 0;

    function automatic logic [7:0] init_byte(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic low;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                mem[i]  = init_byte(i);
                iosp[i] = ~8'(i);
            end
            was_low = 1'b0;
            ready_i = 1'b1;
        end else begin
            low = !memr_n_o || !memw_n_o || !ior_n_o || !iow_n_o;
            if (ale_o) begin
                cur_a      = {a_hi_o, ad_o};
                stall_left = stall_cfg;
                ready_i    = (stall_cfg == 0);
            end
            if (low) begin
                cur_kind = !memr_n_o ? 0 : !memw_n_o ? 1 : !ior_n_o ? 2 : 3;
                ready_i  = (stall_left == 0);
                if (stall_left > 0) stall_left--;
                if (cur_kind == 1 || cur_kind == 3) begin
                    cur_data = ad_o;
                    ad_i     = 8'h5A;
                end else begin
                    cur_data = (cur_kind == 0) ? mem[cur_a[7:0]] : iosp[cur_a[7:0]];
                    ad_i     = cur_data;
                end
            end else begin
                ad_i = 8'h5A;
            end
            if (was_low && !low) begin
                if (log_n < 64) begin
                    log_addr[log_n] = cur_a;
                    log_kind[log_n] = cur_kind;
                    log_data[log_n] = cur_data;
                    log_n++;
                end
                if (cur_kind == 1) mem[cur_a[7:0]] = cur_data;
                if (cur_kind == 3) iosp[cur_a[7:0]] = cur_data;
                chk(!ad_oe_o && !ale_o, "R11 release cycle oe", 32'(ad_oe_o), 0);
            end
            was_low = low;
        end
    end

    // Issues one request and returns clocks from accepting edge to done.
    task automatic do_req(input bit wr, input bit io, input logic [19:0] a,
                          input logic [15:0] wd, output int lat);
        @(negedge clk);
        req_write_i = wr; req_io_i = io; req_addr_i = a; req_wdata_i = wd;
        req_i = 1'b1;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        req_i = 1'b0;
        chk(busy_o === 1'b1, "R10 busy after accept", 32'(busy_o), 1);
        while (!done_o && lat < 300) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk(busy_o === 1'b0, "R10 busy low with done", 32'(busy_o), 0);
        @(negedge clk);
        chk(done_o === 1'b0, "R10 done one clock", 32'(done_o), 0);
    endtask

    task automatic chk_pair(input int base, input logic [19:0] a, input int kind,
                            input logic [15:0] word, input string tag);
        chk(log_n == base + 2, {tag, " cycle count"}, 32'(log_n - base), 2);
        chk(log_addr[base] == a, {tag, " first addr"}, 32'(log_addr[base]), 32'(a));
        chk(log_addr[base+1] == 20'(a + 20'd1), {tag, " second addr"},
            32'(log_addr[base+1]), 32'(20'(a + 20'd1)));
        chk(log_kind[base] == kind && log_kind[base+1] == kind, {tag, " command"},
            32'(log_kind[base+1]), 32'(kind));
        chk(log_data[base] == word[7:0], {tag, " low byte"}, 32'(log_data[base]), 32'(word[7:0]));
        chk(log_data[base+1] == word[15:8], {tag, " high byte"}, 32'(log_data[base+1]), 32'(word[15:8]));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(memr_n_o && memw_n_o && ior_n_o && iow_n_o, "R1 strobes high", 32'({memr_n_o, memw_n_o, ior_n_o, iow_n_o}), 32'hF);
        chk(!ale_o && !ad_oe_o, "R1 ale and oe low", 32'({ale_o, ad_oe_o}), 0);
        chk(!busy_o && !done_o, "R1 busy and done low", 32'({busy_o, done_o}), 0);
    endtask

    task automatic t_mem_write_read();
        int base, lat;
        logic [15:0] prev;
        prev = rdata_o;
        base = log_n;
        do_req(1'b1, 1'b0, 20'h12345, 16'hBEEF, lat);
        chk_pair(base, 20'h12345, 1, 16'hBEEF, "R4 R2 R6 mem write");
        chk(lat == 8, "R9 latency no wait", 32'(lat), 8);
        chk(rdata_o == prev, "R5 write leaves result", 32'(rdata_o), 32'(prev));
        base = log_n;
        do_req(1'b0, 1'b0, 20'h12345, 16'h0000, lat);
        chk_pair(base, 20'h12345, 0, 16'hBEEF, "R2 R6 mem read");
        chk(rdata_o == 16'hBEEF, "R5 read word", 32'(rdata_o), 32'hBEEF);
    endtask

    task automatic t_io();
        int base, lat;
        base = log_n;
        do_req(1'b1, 1'b1, 20'h003F0, 16'h1234, lat);
        chk_pair(base, 20'h003F0, 3, 16'h1234, "R4 R6 io write");
        base = log_n;
        do_req(1'b0, 1'b1, 20'h003F0, 16'h0000, lat);
        chk_pair(base, 20'h003F0, 2, 16'h1234, "R6 io read");
        chk(rdata_o == 16'h1234, "R5 io read word", 32'(rdata_o), 32'h1234);
        do_req(1'b0, 1'b1, 20'h00080, 16'h0000, lat);
        chk(rdata_o == 16'h7E7F, "R5 R6 io space separate", 32'(rdata_o), 32'h7E7F);
    endtask

    task automatic t_wrap();
        int base, lat;
        logic [15:0] exp;
        exp = {init_byte(0), init_byte(255)};
        base = log_n;
        do_req(1'b0, 1'b0, 20'hFFFFF, 16'h0000, lat);
        chk(log_addr[base+1] == 20'h00000, "R3 wrap address", 32'(log_addr[base+1]), 0);
        chk(rdata_o == exp, "R3 R5 wrap read", 32'(rdata_o), 32'(exp));
    endtask

    task automatic t_stall();
        int lat;
        logic [15:0] exp;
        exp = {init_byte(8'hCE), init_byte(8'hCD)};
        stall_cfg = 3;
        do_req(1'b0, 1'b0, 20'h0ABCD, 16'h0000, lat);
        stall_cfg = 0;
        chk(lat == 14, "R9 latency with 3 wait clocks", 32'(lat), 14);
        chk(rdata_o == exp, "R9 R5 stalled read", 32'(rdata_o), 32'(exp));
    endtask

    task automatic t_busy_ignore();
        int base, cnt;
        base = log_n;
        @(negedge clk);
        req_write_i = 1'b0; req_io_i = 1'b0; req_addr_i = 20'h00200; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (3) @(negedge clk);
        req_write_i = 1'b1; req_io_i = 1'b1; req_addr_i = 20'h00300;
        req_wdata_i = 16'hAAAA; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        cnt = 0;
        while (!done_o && cnt < 300) begin
            @(negedge clk);
            cnt++;
        end
        repeat (12) @(negedge clk);
        chk(log_n == base + 2, "R10 request while busy ignored", 32'(log_n - base), 2);
        chk(log_addr[base] == 20'h00200 && log_kind[base+1] == 0, "R10 only first request ran",
            32'(log_addr[base]), 32'h200);
        chk(!busy_o, "R10 idle after ignored request", 32'(busy_o), 0);
        chk(iosp[8'h00] == 8'hFF, "R10 ignored write left io untouched", 32'(iosp[8'h00]), 32'hFF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_mem_write_read();
        t_io();
        t_wrap();
        t_stall();
        t_busy_ignore();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule